// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer

This block turns a serial bit stream into parallel words. It works on the falling edge of a high-speed bit clock and samples one serial bit per bit period into an input register. It then shifts that bit into a shift register. A divide counter groups the samples into words of `WORD_W` bits, 16 by default. Once per word period the assembled word is copied into a parallel output register, and it holds there for a full word period.

The block also divides the bit clock by `WORD_W` and drives the result out as a word clock. The parallel output changes shortly after the word clock falls and is steady well before the next rising edge. Downstream logic can therefore capture the word on the rising edge of the exported clock. Word alignment is fixed by reset: the first bit sampled after reset is released becomes bit 0 of the first word. No framing search is done.

Top module: `deser_word`

## Requirements
- R1: The serial input is sampled only on falling edges of the bit clock; a level that changes and changes back between two falling edges has no effect on the output word.
- R2: The divide counter steps by one on every falling bit-clock edge from 0 to WORD_W-1 and then wraps to 0.
- R3: The word clock is low while the counter is below WORD_W/2 and high otherwise. Its period is WORD_W bit periods with a 50% duty cycle, and it is low during the first WORD_W/2 bit periods after reset release.
- R4: The parallel output loads only on the falling bit-clock edge at which the counter leaves 0, which is one bit period after the word clock falls. It holds its value at all other edges.
- R5: Inside a word, the first bit sampled lands on output bit 0 and the last bit sampled lands on output bit WORD_W-1.
- R6: Number the falling edges from 1, starting after reset release. Word k (k ≥ 1) is made of the samples taken at edges (k-1)·WORD_W+1 through k·WORD_W. It is presented after edge k·WORD_W+1.
- R7: While rst_ni is low, the parallel output is all zeros and the word clock is low, whatever the serial input does.
- R8: A reset in the middle of a word discards the partial word. After release, alignment restarts so that the next bit sampled becomes bit 0 of a new word.
- R9: The parallel output does not change at the bit-clock edge where the word clock rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | High-speed bit clock; falling edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| serial_i | input | 1 | Serial data, one bit per bit period |
| word_o | output | WORD_W | Parallel word, first-received bit on bit 0 |
| word_clk_o | output | 1 | Bit clock divided by WORD_W |

## Verification
The bench builds the block with WORD_W = 16, the default. With that width, the counter wrap, the half-period word-clock phases and the 15-bit shift history can all be checked at their real sizes. A fixed table of edge-pattern words (single set bits at both ends, alternating bits, all ones, all zeros) checks that every bit position is placed correctly. Random words and a reset in the middle of a word then check latency and realignment.

// File: rtl/deser_pkg.sv
package deser_pkg;
  parameter int unsigned DEF_WORD_W = 16;

  function automatic int unsigned cnt_width(input int unsigned w);
    return (w > 2) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/deser_timing.sv
module deser_timing #(
  parameter int unsigned WORD_W = deser_pkg::DEF_WORD_W,
  localparam int unsigned CNT_W = deser_pkg::cnt_width(WORD_W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic word_clk_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(WORD_W / 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wclk_q;

  assign cnt_d = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wclk_q <= (cnt_d >= HALF_C);
    end
  end

  // load on the edge that leaves count 0 (input register adds one stage)
  assign load_o     = (cnt_q == '0);
  assign word_clk_o = wclk_q;

  p_cnt_wrap_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST_C) |=> (cnt_q == '0));
  p_cnt_step_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST_C) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_wclk_low_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cnt_q < HALF_C) |-> !wclk_q);
endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
  parameter int unsigned WORD_W = deser_pkg::DEF_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_i,
  output logic [WORD_W-1:0] next_word_o
);
  logic              din_q;
  logic [WORD_W-2:0] hist_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q  <= 1'b0;
      hist_q <= '0;
    end else begin
      din_q  <= serial_i;
      hist_q <= {din_q, hist_q[WORD_W-2:1]};
    end
  end

  // oldest sample sits at bit 0, newest at the top
  assign next_word_o = {din_q, hist_q};

  p_shift_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    hist_q[WORD_W-3] == $past(hist_q[WORD_W-2]));
  p_top_in_r1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    hist_q[WORD_W-2] == $past(din_q));
endmodule

// File: rtl/deser_out_reg.sv
module deser_out_reg #(
  parameter int unsigned WORD_W = deser_pkg::DEF_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_o <= '0;
    else if (load_i) word_o <= word_i;
  end

  p_hold_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(word_o));
endmodule

// File: rtl/deser_word.sv
module deser_word #(
  parameter int unsigned WORD_W = deser_pkg::DEF_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_clk_o
);
  logic              load;
  logic [WORD_W-1:0] next_word;

  if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_bad_w
    initial $error("WORD_W must be even and at least 4");
  end

  deser_timing #(.WORD_W(WORD_W)) i_timing (
    .clk_i, .rst_ni, .load_o(load), .word_clk_o
  );

  deser_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i, .rst_ni, .serial_i, .next_word_o(next_word)
  );

  deser_out_reg #(.WORD_W(WORD_W)) i_out (
    .clk_i, .rst_ni, .load_i(load), .word_i(next_word), .word_o
  );

  p_stable_at_rise_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(word_clk_o) |-> $stable(word_o));
  p_load_after_fall_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> ($past(word_clk_o) == 1'b0));
endmodule

// File: tb/test_deser_word.sv
module test_deser_word;
  localparam int W = 16;
  localparam int NTAB = 8;
  localparam logic [W-1:0] VEC [NTAB] = '{16'h0001, 16'h8000, 16'hAAAA, 16'h5555,
                                          16'hFFFF, 16'h0000, 16'h1234, 16'hC3A5};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         serial_i = 1'b0;
  logic [W-1:0] word_o;
  logic         word_clk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [W-1:0] stim [16];

  deser_word #(.WORD_W(W)) i_deser_word (
    .clk_i, .rst_ni, .serial_i, .word_o, .word_clk_o
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // release reset at a rising edge and stream n words plus one flush word
  task automatic run_words(input int n, input bit glitch);
    logic [W-1:0] last;
    last = '0;
    @(posedge clk_i);
    rst_ni   = 1'b1;
    serial_i = stim[0][0];
    for (int j = 1; j <= (n + 1) * W; j++) begin
      @(posedge clk_i);
      // j falling edges have occurred since release
      chk(word_clk_o == ((j % W) >= W / 2), "R3", W'(word_clk_o), W'((j % W) >= W / 2));
      if ((j % W) == 1 && j > W) begin
        last = stim[j / W - 1];
        chk(word_o == last, "R6 R5", word_o, last);
      end else if ((j % W) == W / 2 + 1) begin
        chk(word_o == last, "R4 R9", word_o, last);
      end
      serial_i = (j < n * W) ? stim[j / W][j % W] : 1'b0;
      if (glitch && j < n * W) begin
        // R1: flip between falling edges, restore before the next one
        #1 serial_i = ~serial_i;
        #2 serial_i = ~serial_i;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(word_o == '0, "R7", word_o, '0);
    chk(word_clk_o == 1'b0, "R7", W'(word_clk_o), '0);

    // table walk
    for (int i = 0; i < NTAB; i++) stim[i] = VEC[i];
    run_words(NTAB, 1'b0);

    // random words with glitches between sampling edges (R1)
    for (int i = 0; i < 6; i++) stim[i] = W'($urandom);
    @(posedge clk_i); rst_ni = 1'b0;
    run_words(6, 1'b1);

    // mid-word reset: half a word of ones, then reset (R7, R8)
    for (int i = 0; i < W / 2 + 3; i++) begin
      @(posedge clk_i); serial_i = 1'b1;
    end
    @(posedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(word_o == '0, "R7", word_o, '0);
    chk(word_clk_o == 1'b0, "R7", W'(word_clk_o), '0);
    repeat (2) @(posedge clk_i);
    #1;
    chk(word_o == '0, "R7", word_o, '0);
    stim[0] = 16'h0F01;
    stim[1] = W'($urandom);
    run_words(2, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule